// File: doc/BRIEF.md
# Load/Store Address Micro-Translation Buffer

This block is a tiny, fully associative translation cache for load and store addresses. It holds three 4 KB page translations in flops and compares all of them in parallel every cycle. A larger main translation buffer, outside this block, is probed with the same address in the same cycle. Its answer arrives on the `mt_*` inputs before the clock edge. A local hit returns the physical address on the next cycle. A local miss that the main buffer can answer writes a new entry at that same edge and raises a one-cycle stall; the requester repeats the access and it then hits. A miss in both raises a miss flag and changes nothing.

The requester cannot read or write the entries. Only hardware fills them, and a flush input empties them whenever the main buffer is rewritten. Main-buffer pages larger than 4 KB are narrowed to the 4 KB slice that holds the requested address before they are stored. The low `MASK_W` bits of the main buffer's frame number are then taken from the virtual page number wherever the page mask has a 1.

Top module: `dutlb_top`

## Requirements
- R1: After synchronous reset, `hit_o`, `stall_o` and `miss_o` are low and no entry is valid, so the first lookup of any page is a local miss.
- R2: An accepted request (`req_i`=1, `flush_i`=0) whose VPN (`va_i[31:12]`) matches a valid entry sets `hit_o` one cycle later. In that cycle `pa_o` = {entry PFN, `va_i[11:0]`} and `attr_o` = the entry's attribute bits.
- R3: An accepted request that misses locally while `mt_hit_i`=1 sets `stall_o` for exactly one cycle and writes the translation at that edge. The same request repeated on the next cycle hits.
- R4: The stored PFN is (`mt_pfn_i` with the low 8 bits cleared where `mt_mask_i` is 1) OR (`va_i[19:12]` AND `mt_mask_i`). The stored ASID is `asid_i`, the global bit is `mt_glob_i`, and the attribute is `mt_attr_i`.
- R5: An accepted request that misses locally with `mt_hit_i`=0 sets `miss_o` one cycle later and leaves all entries and the victim pointer unchanged.
- R6: Refills go to entries 0, 1, 2, 0, ... in round-robin order. After three distinct pages are filled, a fourth evicts the first and keeps the other two.
- R7: `flush_i`=1 invalidates all entries and returns the victim pointer to entry 0 within that cycle. A request in the same cycle is dropped: no flag rises and nothing is written.
- R8: With `req_i`=0, no flag rises on the next cycle and the `mt_*` inputs are not stored.
- R9: At most one of `hit_o`, `stall_o`, `miss_o` is high in any cycle.
- R10: An entry matches when its VPN matches and either its global bit is set or its ASID equals `asid_i`. A non-global entry presented with another ASID is a local miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Lookup request strobe |
| flush_i | input | 1 | Invalidate all entries |
| va_i | input | 32 | Virtual address |
| asid_i | input | 8 | Current address-space identifier |
| mt_hit_i | input | 1 | Main buffer hit for this cycle's address |
| mt_pfn_i | input | 20 | Main buffer frame number (page base) |
| mt_mask_i | input | 8 | Main buffer page-size mask over the low frame bits |
| mt_glob_i | input | 1 | Main buffer global bit |
| mt_attr_i | input | 4 | Main buffer cache/dirty attribute bits |
| hit_o | output | 1 | Registered: translation valid |
| stall_o | output | 1 | Registered: refilled, repeat the access |
| miss_o | output | 1 | Registered: missed in both buffers |
| pa_o | output | 32 | Registered physical address, updated on hit |
| attr_o | output | 4 | Registered attribute bits, updated on hit |

## Verification
The hardest state to reach from the ports is a full buffer whose round-robin pointer has wrapped. Reaching it needs three distinct refills followed by a fourth. Only the pattern of later hits and stalls shows which entry was evicted. Directed sequences fill three pages, force the eviction, and then probe all four pages. A random phase draws from eight pages, two ASIDs, mixed page masks, global pages, pages the main buffer rejects, and occasional flushes. The pool is slightly larger than the buffer, so evictions and pointer wraps happen often, and the bench's own reference model predicts every flag and address.

// File: rtl/dutlb_pkg.sv
package dutlb_pkg;
  parameter int VA_W   = 32;
  parameter int OFF_W  = 12;
  parameter int VPN_W  = VA_W - OFF_W;
  parameter int PFN_W  = 20;
  parameter int PA_W   = PFN_W + OFF_W;
  parameter int ASID_W = 8;
  parameter int ATTR_W = 4;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
  } utlb_dat_t;
endpackage

// File: rtl/dutlb_entry.sv
module dutlb_entry
  import dutlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  utlb_dat_t         wr_dat,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              match,
  output utlb_dat_t         dat
);
  logic vld_q;
  utlb_dat_t dat_q;

  always_ff @(posedge clk) begin
    if (rst || flush) vld_q <= 1'b0;
    else if (wr_en)   vld_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) dat_q <= wr_dat;
  end

  always_comb begin
    match = vld_q && (dat_q.vpn == lk_vpn) &&
            (dat_q.glob || (dat_q.asid == lk_asid));
  end

  assign dat = dat_q;
endmodule

// File: rtl/dutlb_victim.sv
module dutlb_victim #(
  parameter int N  = 3,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(N - 1);
  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) ptr_q <= '0;
    else if (adv)   ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/dutlb_subpage.sv
module dutlb_subpage
  import dutlb_pkg::*;
#(
  parameter int MASK_W = 8
) (
  input  logic [PFN_W-1:0]  base,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [MASK_W-1:0] mask,
  output logic [PFN_W-1:0]  pfn
);
  localparam int PAD = PFN_W - MASK_W;
  logic [PFN_W-1:0] wmask;
  logic [PFN_W-1:0] low;

  always_comb begin
    wmask = {{PAD{1'b0}}, mask};
    low   = {{PAD{1'b0}}, vpn[MASK_W-1:0]};
    pfn   = (base & ~wmask) | (low & wmask);
  end
endmodule

// File: rtl/dutlb_top.sv
module dutlb_top
  import dutlb_pkg::*;
#(
  parameter int ENTRIES = 3,
  parameter int MASK_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              flush_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              mt_hit_i,
  input  logic [PFN_W-1:0]  mt_pfn_i,
  input  logic [MASK_W-1:0] mt_mask_i,
  input  logic              mt_glob_i,
  input  logic [ATTR_W-1:0] mt_attr_i,
  output logic              hit_o,
  output logic              stall_o,
  output logic              miss_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [ATTR_W-1:0] attr_o
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] wr_en;
  utlb_dat_t          ent_dat [ENTRIES];
  utlb_dat_t          sel_dat;
  utlb_dat_t          fill_dat;
  logic [PFN_W-1:0]   fill_pfn;
  logic [PW-1:0]      vic_ptr;
  logic               accept, any_hit, refill, dbl_miss;

  assign lk_vpn = va_i[VA_W-1:OFF_W];
  assign lk_off = va_i[OFF_W-1:0];

  always_comb begin
    accept   = req_i && !flush_i;
    any_hit  = |match;
    refill   = accept && !any_hit && mt_hit_i;
    dbl_miss = accept && !any_hit && !mt_hit_i;
  end

  dutlb_subpage #(.MASK_W(MASK_W)) subpage_i (
    .base (mt_pfn_i),
    .vpn  (lk_vpn),
    .mask (mt_mask_i),
    .pfn  (fill_pfn)
  );

  always_comb begin
    fill_dat.vpn  = lk_vpn;
    fill_dat.asid = asid_i;
    fill_dat.glob = mt_glob_i;
    fill_dat.pfn  = fill_pfn;
    fill_dat.attr = mt_attr_i;
  end

  dutlb_victim #(.N(ENTRIES)) victim_i (
    .clk (clk),
    .rst (rst),
    .clr (flush_i),
    .adv (refill),
    .ptr (vic_ptr)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign wr_en[g] = refill && (vic_ptr == PW'(g));

    dutlb_entry entry_i (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush_i),
      .wr_en   (wr_en[g]),
      .wr_dat  (fill_dat),
      .lk_vpn  (lk_vpn),
      .lk_asid (asid_i),
      .match   (match[g]),
      .dat     (ent_dat[g])
    );
  end

  always_comb begin
    sel_dat = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) sel_dat = utlb_dat_t'(sel_dat | ent_dat[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o   <= 1'b0;
      stall_o <= 1'b0;
      miss_o  <= 1'b0;
      pa_o    <= '0;
      attr_o  <= '0;
    end else begin
      hit_o   <= accept && any_hit;
      stall_o <= refill;
      miss_o  <= dbl_miss;
      if (accept && any_hit) begin
        pa_o   <= {sel_dat.pfn, lk_off};
        attr_o <= sel_dat.attr;
      end
    end
  end
endmodule

// File: rtl/dutlb_chk.sv
module dutlb_chk
  import dutlb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic              flush_i,
  input logic [VA_W-1:0]   va_i,
  input logic [ASID_W-1:0] asid_i,
  input logic              mt_hit_i,
  input logic              hit_o,
  input logic              stall_o,
  input logic              miss_o
);
  assert_one_flag_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_o, stall_o, miss_o}));

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (hit_o || stall_o || miss_o) |-> $past(req_i && !flush_i));

  assert_miss_needs_main_miss_R5: assert property (@(posedge clk) disable iff (rst)
    miss_o |-> $past(!mt_hit_i));

  assert_stall_needs_main_hit_R3: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> $past(mt_hit_i));

  assert_retry_hits_R3: assert property (@(posedge clk) disable iff (rst)
    (stall_o && req_i && !flush_i &&
     (va_i[VA_W-1:OFF_W] == $past(va_i[VA_W-1:OFF_W])) &&
     (asid_i == $past(asid_i))) |=> hit_o);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    (flush_i ##1 (req_i && !flush_i)) |=> !hit_o);
endmodule

bind dutlb_top dutlb_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .req_i    (req_i),
  .flush_i  (flush_i),
  .va_i     (va_i),
  .asid_i   (asid_i),
  .mt_hit_i (mt_hit_i),
  .hit_o    (hit_o),
  .stall_o  (stall_o),
  .miss_o   (miss_o)
);

// File: tb/dutlb_top_tb_top.sv
`timescale 1ns/1ps
module dutlb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_i, flush_i, mt_hit_i, mt_glob_i;
  logic [31:0] va_i;
  logic [7:0]  asid_i, mt_mask_i;
  logic [19:0] mt_pfn_i;
  logic [3:0]  mt_attr_i, attr_o;
  logic        hit_o, stall_o, miss_o;
  logic [31:0] pa_o;

  int total = 0;
  int fails = 0;

  // reference model state
  logic        m_v    [3];
  logic [19:0] m_vpn  [3];
  logic [7:0]  m_asid [3];
  logic        m_g    [3];
  logic [19:0] m_pfn  [3];
  logic [3:0]  m_attr [3];
  int          m_ptr;

  always #5 clk = ~clk;

  dutlb_top dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .flush_i(flush_i), .va_i(va_i),
    .asid_i(asid_i), .mt_hit_i(mt_hit_i), .mt_pfn_i(mt_pfn_i),
    .mt_mask_i(mt_mask_i), .mt_glob_i(mt_glob_i), .mt_attr_i(mt_attr_i),
    .hit_o(hit_o), .stall_o(stall_o), .miss_o(miss_o), .pa_o(pa_o),
    .attr_o(attr_o)
  );

  // main-buffer stand-in: answers are a fixed function of the address
  function automatic logic mt_ok(input logic [31:0] va);
    return va[31:28] != 4'hF;
  endfunction
  function automatic logic [19:0] mt_base(input logic [31:0] va);
    return {va[31:24] ^ 8'h5A, 4'h3, 8'hC5};
  endfunction
  function automatic logic [7:0] mt_msk(input logic [31:0] va);
    case (va[27:26])
      2'd1:    return 8'h0F;
      2'd2:    return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
  function automatic logic [19:0] sub_pfn(input logic [31:0] va);
    logic [19:0] wm;
    wm = {12'h0, mt_msk(va)};
    return (mt_base(va) & ~wm) | ({12'h0, va[19:12]} & wm);
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic rq, input logic fl, input logic [31:0] va,
                      input logic [7:0] asid, input logic mh, input string tag,
                      output logic stalled);
    logic e_hit, e_stall, e_miss;
    logic [31:0] e_pa;
    logic [3:0]  e_attr;
    e_hit = 0; e_stall = 0; e_miss = 0; e_pa = '0; e_attr = '0;
    req_i = rq; flush_i = fl; va_i = va; asid_i = asid; mt_hit_i = mh;
    mt_pfn_i = mt_base(va); mt_mask_i = mt_msk(va);
    mt_glob_i = va[25]; mt_attr_i = va[23:20];
    if (fl) begin
      for (int i = 0; i < 3; i++) m_v[i] = 1'b0;
      m_ptr = 0;
    end else if (rq) begin
      for (int i = 0; i < 3; i++) begin
        if (m_v[i] && m_vpn[i] == va[31:12] && (m_g[i] || m_asid[i] == asid)) begin
          e_hit = 1; e_pa = {m_pfn[i], va[11:0]}; e_attr = m_attr[i];
        end
      end
      if (!e_hit && mh) begin
        e_stall = 1;
        m_v[m_ptr] = 1'b1; m_vpn[m_ptr] = va[31:12]; m_asid[m_ptr] = asid;
        m_g[m_ptr] = va[25]; m_pfn[m_ptr] = sub_pfn(va); m_attr[m_ptr] = va[23:20];
        m_ptr = (m_ptr + 1) % 3;
      end else if (!e_hit) begin
        e_miss = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(hit_o == e_hit, tag, "hit_o", 32'(hit_o), 32'(e_hit));
    check(stall_o == e_stall, tag, "stall_o", 32'(stall_o), 32'(e_stall));
    check(miss_o == e_miss, tag, "miss_o", 32'(miss_o), 32'(e_miss));
    check($countones({hit_o, stall_o, miss_o}) <= 1, "R9", "flag count",
          32'($countones({hit_o, stall_o, miss_o})), 32'd1);
    if (e_hit) begin
      check(pa_o == e_pa, tag, "pa_o", pa_o, e_pa);
      check(attr_o == e_attr, tag, "attr_o", 32'(attr_o), 32'(e_attr));
    end
    stalled = e_stall;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input string tag);
    logic st;
    step(1'b1, 1'b0, va, asid, mt_ok(va), tag, st);
    if (st) step(1'b1, 1'b0, va, asid, mt_ok(va), "R3", st);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic st;
    logic [31:0] pg_a, pg_g, pg_big, p0, p1, p2, p3, pg_bad, pg_q, va;
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) m_v[i] = 1'b0;
    m_ptr = 0;
    rst = 1; req_i = 0; flush_i = 0; va_i = '0; asid_i = '0; mt_hit_i = 0;
    mt_pfn_i = '0; mt_mask_i = '0; mt_glob_i = 0; mt_attr_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!hit_o && !stall_o && !miss_o, "R1", "flags after reset",
          {29'h0, hit_o, stall_o, miss_o}, 32'h0);

    pg_a   = 32'h1030_1ABC;   // 4 KB page, non-global, attr 3
    pg_g   = 32'h2270_2004;   // global page (bit 25)
    pg_big = 32'h1B8C_5ABC;   // mask 0xFF page
    // R1: empty buffer, first lookup stalls then retry hits
    step(1'b1, 1'b0, pg_a, 8'd1, 1'b1, "R1", st);
    check(st, "R1", "model stall", 32'(st), 32'd1);
    step(1'b1, 1'b0, pg_a, 8'd1, 1'b1, "R3", st);
    // R2: hit with different offset
    look(pg_a ^ 32'h0000_0FFF, 8'd1, "R2");
    // R10: other ASID misses locally on a non-global page
    step(1'b1, 1'b0, pg_a, 8'd2, 1'b1, "R10", st);
    check(st, "R10", "asid mismatch stalls", 32'(st), 32'd1);
    step(1'b1, 1'b0, pg_a, 8'd2, 1'b1, "R10", st);
    look(pg_g, 8'd1, "R10");
    look(pg_g, 8'd77, "R10");
    // R4: large page narrowed to its 4 KB slice
    step(1'b1, 1'b1, 32'h0, 8'd0, 1'b0, "R7", st);
    look(pg_big, 8'd3, "R4");
    look(pg_big, 8'd3, "R4");
    check(pa_o == {20'h413C5, 12'hABC}, "R4", "sub-page pa", pa_o, {20'h413C5, 12'hABC});
    look(32'h1780_0123, 8'd3, "R4");   // mask 0x0F page

    // R6: round-robin eviction
    step(1'b1, 1'b1, 32'h0, 8'd0, 1'b0, "R7", st);
    p0 = 32'h3000_0000; p1 = 32'h4010_0000; p2 = 32'h5020_0000; p3 = 32'h6030_0000;
    look(p0, 8'd5, "R6"); look(p1, 8'd5, "R6"); look(p2, 8'd5, "R6");
    look(p3, 8'd5, "R6");
    step(1'b1, 1'b0, p1, 8'd5, 1'b1, "R6", st);
    check(!st, "R6", "entry 1 kept", 32'(st), 32'd0);
    step(1'b1, 1'b0, p2, 8'd5, 1'b1, "R6", st);
    check(!st, "R6", "entry 2 kept", 32'(st), 32'd0);
    step(1'b1, 1'b0, p0, 8'd5, 1'b1, "R6", st);
    check(st, "R6", "entry 0 evicted", 32'(st), 32'd1);
    step(1'b1, 1'b0, p0, 8'd5, 1'b1, "R6", st);

    // R5: both miss, contents unchanged
    pg_bad = 32'hF555_0000;
    step(1'b1, 1'b0, pg_bad, 8'd5, 1'b0, "R5", st);
    step(1'b1, 1'b0, pg_bad, 8'd5, 1'b0, "R5", st);
    look(p2, 8'd5, "R5");
    look(p3, 8'd5, "R5");

    // R8: idle cycle with main-buffer data present stores nothing
    pg_q = 32'h7040_0000;
    step(1'b0, 1'b0, pg_q, 8'd5, 1'b1, "R8", st);
    step(1'b1, 1'b0, pg_q, 8'd5, 1'b1, "R8", st);
    check(st, "R8", "idle did not fill", 32'(st), 32'd1);
    step(1'b1, 1'b0, pg_q, 8'd5, 1'b1, "R8", st);

    // R7: flush with a simultaneous request
    step(1'b1, 1'b1, pg_q, 8'd5, 1'b1, "R7", st);
    step(1'b1, 1'b0, pg_q, 8'd5, 1'b1, "R7", st);
    check(st, "R7", "flushed entry gone", 32'(st), 32'd1);
    step(1'b1, 1'b0, pg_q, 8'd5, 1'b1, "R7", st);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int k, r;
      k = $urandom % 8;
      r = $urandom % 100;
      va = {(k == 7) ? 4'hF : 4'(k), 2'(k % 3), (k == 4), 1'b0, 4'(k),
            8'(k * 17), 12'($urandom)};
      if (r < 4)
        step(1'b1, 1'b1, va, 8'($urandom % 2), mt_ok(va), "R7", st);
      else if (r < 14)
        step(1'b0, 1'b0, va, 8'($urandom % 2), mt_ok(va), "R8", st);
      else
        look(va, 8'($urandom % 2), "R2");
    end
    summary();
  end
endmodule